// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Default-Owner Policy

This block decides which of several bus masters owns one shared slave port. It sits in front of each slave of a multi-master bus matrix, one instance per slave. Each cycle it sees which masters want the slave. A separate burst-boundary detector tells it when the ownership may legally change. At such a point it picks a winner by either round-robin or fixed priority. When nobody is asking, it applies a default-owner policy.

The grant is held in registers and changes only on a clock edge where `rearb_ok_i` is high. This prevents a burst from being broken in the middle. When no master requests at a legal point, the slave can be left unowned, kept with its most recent owner, or handed to a configured fixed master. The current owner index and an idle flag are presented next to the one-hot grant.

Top module: `slave_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `grant_o` is all zero, `idle_o` is 1 and `owner_o` is 0.
- R2: On a clock edge where `rearb_ok_i` is 0, `grant_o`, `owner_o` and `idle_o` keep their values, whatever the requests and configuration do.
- R3: `grant_o` has at most one bit set. `idle_o` is 1 exactly when `grant_o` is zero. When not idle, the set bit of `grant_o` is at position `owner_o`.
- R4: With `alg_sel_i` = 0 (round-robin) and at least one request at a legal edge, the winner is the first requesting master found by searching `owner_o`+1, `owner_o`+2, … modulo the master count. The current owner is searched last.
- R5: With `alg_sel_i` = 1 (fixed priority) and at least one request at a legal edge, master i's priority is `prio_i[2i+1:2i]`. The larger value wins, and among equal values the lowest index wins.
- R6: With `park_mode_i` equal to 0 or 3 and no request at a legal edge, the grant becomes zero, `idle_o` becomes 1 and `owner_o` keeps its value.
- R7: With `park_mode_i` = 1 and no request at a legal edge, the grant goes to (or stays with) master `owner_o`, and `idle_o` becomes 0.
- R8: With `park_mode_i` = 2 and no request at a legal edge, the grant and `owner_o` move to master `park_idx_i`. In every other mode, `park_idx_i` has no effect.
- R9: With `park_mode_i` = 2, no request at a legal edge, and `park_idx_i` not below the master count, the slave becomes idle as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N | Per-master request vector |
| prio_i | input | N*PW | Per-master priority, PW bits each, master 0 in the low bits |
| alg_sel_i | input | 1 | 0 round-robin, 1 fixed priority |
| park_mode_i | input | 2 | Default-owner policy: 0 none, 1 last owner, 2 fixed index, 3 none |
| park_idx_i | input | PARK_W | Fixed default-owner index |
| rearb_ok_i | input | 1 | High in cycles where ownership may change |
| grant_o | output | N | One-hot grant, zero when idle |
| owner_o | output | $clog2(N) | Index of current or most recent owner |
| idle_o | output | 1 | No master owns the slave |

## Verification
The bench builds the arbiter with six masters, two-bit priorities and a four-bit default-owner index. A master count that is not a power of two makes the round-robin wrap go through a non-binary modulo. It also makes index values 6 to 15 legal on the default-owner input, so the out-of-range fixed index of R9 can be reached. With six masters, every grant pattern and every round-robin pointer position occurs many times within a few thousand random cycles, alongside directed tie, wrap and parking cases.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int MAX_IDX_W = 8;

    typedef enum logic [1:0] {
        PARK_NONE     = 2'd0,
        PARK_LAST     = 2'd1,
        PARK_FIXED    = 2'd2,
        PARK_NONE_ALT = 2'd3
    } park_mode_e;

    typedef enum logic {
        ALG_ROUND_ROBIN = 1'b0,
        ALG_FIXED_PRIO  = 1'b1
    } alg_e;

    typedef struct packed {
        logic                 hit;
        logic [MAX_IDX_W-1:0] idx;
    } pick_t;

    function automatic logic park_is_none(park_mode_e m);
        return (m == PARK_NONE) || (m == PARK_NONE_ALT);
    endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick
    import arb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] ptr_i,
    output pick_t            pick_o
);

    // Scan from the farthest candidate to the nearest: the last hit wins,
    // which is the first requester after the pointer.
    always_comb begin
        pick_o = '0;
        for (int k = N; k >= 1; k--) begin
            if (req_i[(int'(ptr_i) + k) % N]) begin
                pick_o.hit = 1'b1;
                pick_o.idx = MAX_IDX_W'((int'(ptr_i) + k) % N);
            end
        end
    end

endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import arb_pkg::*;
#(
    parameter int N  = 16,
    parameter int PW = 2
) (
    input  logic [N-1:0]    req_i,
    input  logic [N*PW-1:0] prio_i,
    output pick_t           pick_o
);

    logic [PW-1:0] best;

    // Strictly-greater replacement keeps the lowest index on ties.
    always_comb begin
        pick_o = '0;
        best   = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!pick_o.hit || prio_i[i*PW +: PW] > best)) begin
                pick_o.hit = 1'b1;
                pick_o.idx = MAX_IDX_W'(i);
                best       = prio_i[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
    import arb_pkg::*;
#(
    parameter  int N      = 16,
    parameter  int PW     = 2,
    parameter  int PARK_W = 4,
    localparam int IDX_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      req_i,
    input  logic [N*PW-1:0]   prio_i,
    input  logic              alg_sel_i,
    input  logic [1:0]        park_mode_i,
    input  logic [PARK_W-1:0] park_idx_i,
    input  logic              rearb_ok_i,
    output logic [N-1:0]      grant_o,
    output logic [IDX_W-1:0]  owner_o,
    output logic              idle_o
);

    pick_t            rr_win;
    pick_t            pr_win;
    logic [N-1:0]     grant_q, grant_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic             idle_q, idle_d;
    logic [IDX_W-1:0] win_idx;
    park_mode_e       mode;
    alg_e             alg;
    logic             park_in_range;

    rr_pick #(.N(N), .IDX_W(IDX_W)) u_rr (
        .req_i  (req_i),
        .ptr_i  (owner_q),
        .pick_o (rr_win)
    );

    prio_pick #(.N(N), .PW(PW)) u_prio (
        .req_i  (req_i),
        .prio_i (prio_i),
        .pick_o (pr_win)
    );

    assign mode          = park_mode_e'(park_mode_i);
    assign alg           = alg_e'(alg_sel_i);
    assign park_in_range = int'(park_idx_i) < N;
    assign win_idx       = (alg == ALG_FIXED_PRIO) ? pr_win.idx[IDX_W-1:0]
                                                   : rr_win.idx[IDX_W-1:0];

    always_comb begin
        grant_d = grant_q;
        owner_d = owner_q;
        idle_d  = idle_q;
        if (rearb_ok_i) begin
            if (|req_i) begin
                grant_d = N'(1) << win_idx;
                owner_d = win_idx;
                idle_d  = 1'b0;
            end else if (mode == PARK_LAST) begin
                grant_d = N'(1) << owner_q;
                idle_d  = 1'b0;
            end else if (mode == PARK_FIXED && park_in_range) begin
                grant_d = N'(1) << park_idx_i;
                owner_d = IDX_W'(park_idx_i);
                idle_d  = 1'b0;
            end else begin
                grant_d = '0;
                idle_d  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            owner_q <= '0;
            idle_q  <= 1'b1;
        end else begin
            grant_q <= grant_d;
            owner_q <= owner_d;
            idle_q  <= idle_d;
        end
    end

    assign grant_o = grant_q;
    assign owner_o = owner_q;
    assign idle_o  = idle_q;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N      = 16,
    parameter int PW     = 2,
    parameter int PARK_W = 4,
    parameter int IDX_W  = $clog2(N)
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      req_i,
    input logic [N*PW-1:0]   prio_i,
    input logic              alg_sel_i,
    input logic [1:0]        park_mode_i,
    input logic [PARK_W-1:0] park_idx_i,
    input logic              rearb_ok_i,
    input logic [N-1:0]      grant_o,
    input logic [IDX_W-1:0]  owner_o,
    input logic              idle_o
);

    logic no_req;
    logic park_ok;
    assign no_req  = (req_i == '0);
    assign park_ok = int'(park_idx_i) < N;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rearb_ok_i |=> $stable(grant_o) && $stable(owner_o) && $stable(idle_o));

    assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    assert_idle_flag_R3: assert property (@(posedge clk) disable iff (rst)
        idle_o == (grant_o == '0));

    assert_owner_bit_R3: assert property (@(posedge clk) disable iff (rst)
        !idle_o |-> grant_o[owner_o]);

    assert_requester_served_R4: assert property (@(posedge clk) disable iff (rst)
        (rearb_ok_i && !no_req) |=> (grant_o & $past(req_i)) != '0);

    assert_park_none_R6: assert property (@(posedge clk) disable iff (rst)
        (rearb_ok_i && no_req && (park_mode_i == 2'd0 || park_mode_i == 2'd3))
        |=> idle_o && $stable(owner_o));

    assert_park_last_R7: assert property (@(posedge clk) disable iff (rst)
        (rearb_ok_i && no_req && park_mode_i == 2'd1)
        |=> !idle_o && $stable(owner_o));

    assert_park_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (rearb_ok_i && no_req && park_mode_i == 2'd2 && park_ok)
        |=> !idle_o && (int'(owner_o) == int'($past(park_idx_i))));

    assert_park_range_R9: assert property (@(posedge clk) disable iff (rst)
        (rearb_ok_i && no_req && park_mode_i == 2'd2 && !park_ok)
        |=> idle_o);

endmodule

bind slave_arbiter arb_checker #(
    .N(N), .PW(PW), .PARK_W(PARK_W), .IDX_W(IDX_W)
) u_arb_checker (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .prio_i      (prio_i),
    .alg_sel_i   (alg_sel_i),
    .park_mode_i (park_mode_i),
    .park_idx_i  (park_idx_i),
    .rearb_ok_i  (rearb_ok_i),
    .grant_o     (grant_o),
    .owner_o     (owner_o),
    .idle_o      (idle_o)
);

// File: tb/slave_arbiter_bench.sv
module slave_arbiter_bench;

    localparam int N      = 6;
    localparam int PW     = 2;
    localparam int PARK_W = 4;
    localparam int IDX_W  = $clog2(N);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      req_i = '0;
    logic [N*PW-1:0]   prio_i = '0;
    logic              alg_sel_i = 1'b0;
    logic [1:0]        park_mode_i = 2'd0;
    logic [PARK_W-1:0] park_idx_i = '0;
    logic              rearb_ok_i = 1'b0;
    logic [N-1:0]      grant_o;
    logic [IDX_W-1:0]  owner_o;
    logic              idle_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int       m_owner;
    bit       m_idle;
    logic [N-1:0] m_grant;

    always #10 clk = ~clk;

    slave_arbiter #(.N(N), .PW(PW), .PARK_W(PARK_W)) u_slave_arbiter (
        .clk(clk), .rst(rst), .req_i(req_i), .prio_i(prio_i),
        .alg_sel_i(alg_sel_i), .park_mode_i(park_mode_i),
        .park_idx_i(park_idx_i), .rearb_ok_i(rearb_ok_i),
        .grant_o(grant_o), .owner_o(owner_o), .idle_o(idle_o)
    );

    function automatic int rr_model(logic [N-1:0] r, int ptr);
        for (int k = 1; k <= N; k++)
            if (r[(ptr + k) % N]) return (ptr + k) % N;
        return -1;
    endfunction

    function automatic int prio_model(logic [N-1:0] r, logic [N*PW-1:0] p);
        int best = -1;
        int win  = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && int'(p[i*PW +: PW]) > best) begin
                best = int'(p[i*PW +: PW]);
                win  = i;
            end
        return win;
    endfunction

    task automatic check_outputs(string tag);
        checks++;
        if (grant_o !== m_grant || int'(owner_o) != m_owner || idle_o !== m_idle) begin
            errors++;
            $display("FAIL %s: grant=%b owner=%0d idle=%0b expected grant=%b owner=%0d idle=%0b",
                     tag, grant_o, owner_o, idle_o, m_grant, m_owner, m_idle);
        end
        checks++;
        if ($countones(grant_o) > 1 || idle_o !== (grant_o == '0)) begin
            errors++;
            $display("FAIL R3: grant=%b idle=%0b expected at most one bit and idle=%0b",
                     grant_o, idle_o, (grant_o == '0));
        end
    endtask

    // Drive one cycle at a negedge, advance the model, check at the next negedge.
    task automatic cycle(logic [N-1:0] r, logic [N*PW-1:0] p, logic alg,
                         logic [1:0] mode, logic [PARK_W-1:0] pidx, logic ok);
        string tag;
        int    w;
        req_i = r; prio_i = p; alg_sel_i = alg;
        park_mode_i = mode; park_idx_i = pidx; rearb_ok_i = ok;
        if (!ok) tag = "R2";
        else if (r != '0) begin
            if (alg) begin tag = "R5"; w = prio_model(r, p); end
            else     begin tag = "R4"; w = rr_model(r, m_owner); end
            m_grant = N'(1) << w; m_owner = w; m_idle = 1'b0;
        end else if (mode == 2'd1) begin
            tag = "R7"; m_grant = N'(1) << m_owner; m_idle = 1'b0;
        end else if (mode == 2'd2 && int'(pidx) < N) begin
            tag = "R8"; m_owner = int'(pidx); m_grant = N'(1) << m_owner; m_idle = 1'b0;
        end else begin
            tag = (mode == 2'd2) ? "R9" : "R6";
            m_grant = '0; m_idle = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*PW-1:0] eq_prio;
        void'($urandom(32'd20240611));
        m_grant = '0; m_owner = 0; m_idle = 1'b1;
        repeat (3) @(negedge clk);
        check_outputs("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_outputs("R1 after reset");

        // R4: round-robin order and wrap past the last master
        cycle(6'b000001, '0, 1'b0, 2'd0, 4'd0, 1'b1);
        cycle(6'b100011, '0, 1'b0, 2'd0, 4'd0, 1'b1);   // -> 1
        cycle(6'b100011, '0, 1'b0, 2'd0, 4'd0, 1'b1);   // -> 5
        cycle(6'b100011, '0, 1'b0, 2'd0, 4'd0, 1'b1);   // wraps -> 0
        // R2: held while not allowed, even with new requests
        cycle(6'b010000, '0, 1'b0, 2'd2, 4'd3, 1'b0);
        cycle(6'b000000, '0, 1'b1, 2'd0, 4'd3, 1'b0);
        // R5: equal priorities tie to lowest index, then a higher one wins
        eq_prio = {N{2'd2}};
        cycle(6'b110100, eq_prio, 1'b1, 2'd0, 4'd0, 1'b1); // -> 2
        eq_prio[5*PW +: PW] = 2'd3;
        cycle(6'b110100, eq_prio, 1'b1, 2'd0, 4'd0, 1'b1); // -> 5
        // R7 and R8: last-owner parking ignores the fixed index
        cycle(6'b000000, '0, 1'b0, 2'd1, 4'd1, 1'b1);
        cycle(6'b000000, '0, 1'b0, 2'd1, 4'd4, 1'b1);
        cycle(6'b000000, '0, 1'b0, 2'd2, 4'd3, 1'b1);      // R8 -> 3
        cycle(6'b000000, '0, 1'b0, 2'd2, 4'd9, 1'b1);      // R9 -> idle
        cycle(6'b000000, '0, 1'b0, 2'd1, 4'd0, 1'b1);      // R7 after idle
        cycle(6'b000000, '0, 1'b0, 2'd3, 4'd2, 1'b1);      // R6 with code 3
        cycle(6'b000000, '0, 1'b0, 2'd0, 4'd5, 1'b1);      // R6 with code 0
        cycle(6'b000001, '0, 1'b0, 2'd0, 4'd0, 1'b1);      // R4 from idle

        for (int n = 0; n < 4000; n++) begin
            logic [N-1:0] r;
            r = N'($urandom) & N'($urandom);
            if ($urandom_range(0, 3) == 0) r = '0;
            cycle(r, (N*PW)'($urandom), 1'($urandom), 2'($urandom),
                  PARK_W'($urandom), ($urandom_range(0, 9) < 6));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule